// File: doc/BRIEF.md
# GCD Loop Dependence Tester

This unit decides whether two affine array references, one indexed `a*i + b` and the other `c*j + d`, could touch the same element. Setting the two subscripts equal gives `a*i - c*j = d - b`. Integer solutions can exist only when the greatest common divisor of the two index coefficients divides the offset difference. A loop scheduler pulses `start_i` with the four signed coefficients. The unit then reports either a possible dependence, in which case the loop must not be parallelized, or independence, in which case parallel execution is legal.

The unit is a three-state machine. In **IDLE** it waits for a start. The transition *launch* (IDLE to REDUCE) latches `|a|`, `|c|` and `|d - b|`. In **REDUCE** it runs subtractive Euclid, one subtraction per clock, on the two magnitudes. The transition *settle* (REDUCE to DIVIDE) fires when either magnitude is zero or the two are equal, and keeps their bitwise OR as the GCD. In **DIVIDE** it subtracts the GCD from `|d - b|`, once per clock, while the remainder is at least the GCD. The transition *verdict* (DIVIDE to IDLE) fires when the remainder falls below the GCD, or at once when the GCD is zero. It pulses `done_o` and records the verdict: a remainder of zero means a possible dependence.

Top module: `gcd_dep_tester`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `done_o`, `dep_o` and `indep_o` are all 0.
- R2: A `start_i` sampled high in IDLE latches the four coefficients and makes `busy_o` 1 from the next cycle; accepting a start clears both verdict outputs.
- R3: When gcd(|a|,|c|) is nonzero and divides d - b, the result is `dep_o`=1 and `indep_o`=0.
- R4: When gcd(|a|,|c|) does not divide d - b, the result is `dep_o`=0 and `indep_o`=1; a=2, b=0, c=4, d=1 is independent.
- R5: When a and c are both zero, a dependence is reported exactly when d - b equals zero.
- R6: When exactly one of a, c is zero, the GCD is the magnitude of the other coefficient.
- R7: Negative coefficients and a negative difference d - b are handled by their magnitudes, across the full signed 16-bit input range.
- R8: With S_g the number of subtractive Euclid steps on (|a|,|c|) (stopping when either is zero or they are equal), g the GCD, and S_m = floor(|d-b|/g) (0 when g is 0), `done_o` is high in the cycle after clock edge S_g + S_m + 2, counting the edge that accepts the start as edge 0.
- R9: `done_o` is a one-cycle pulse, `busy_o` is 0 while it is high, and exactly one of `dep_o`, `indep_o` is 1 with it.
- R10: A `start_i` while `busy_o` is 1 is ignored: the running test and its latency are unchanged.
- R11: The verdict outputs hold their value from the done pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only in IDLE |
| coef_a_i | input | W | Signed multiplier of the first subscript |
| off_b_i | input | W | Signed offset of the first subscript |
| coef_c_i | input | W | Signed multiplier of the second subscript |
| off_d_i | input | W | Signed offset of the second subscript |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dep_o | output | 1 | Possible dependence; the loop must stay serial |
| indep_o | output | 1 | References are independent; the loop may run in parallel |

## Verification
Latency depends on the data, so the bench model works out S_g and S_m for each stimulus from integer arithmetic. It then predicts the exact clock edge that raises `done_o`, which is edge S_g + S_m + 2 after the start. From that edge on it predicts the verdict. `busy_o` is predicted high from the edge after the accepted start up to the verdict edge. Inputs change on falling edges, and all four outputs are compared with the model at every falling edge, so a result that comes one cycle early or late, a done pulse that is too long, or a verdict that changes while idle all show up as mismatches. Starts issued while busy leave the model's countdown untouched, which checks that the design ignores them.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REDUCE = 2'd1,
        ST_DIVIDE = 2'd2
    } gdt_state_e;
endpackage

// File: rtl/gdt_prep.sv
// Forms the unsigned magnitudes used by the test: |a|, |c| and |d - b|.
module gdt_prep #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] coef_a,
    input  logic signed [W-1:0] off_b,
    input  logic signed [W-1:0] coef_c,
    input  logic signed [W-1:0] off_d,
    output logic        [W-1:0] mag_a,
    output logic        [W-1:0] mag_c,
    output logic        [W-1:0] mag_diff
);
    localparam int DW = W + 1;

    logic signed [DW-1:0] diff;
    logic        [DW-1:0] diff_abs;

    always_comb begin
        diff     = DW'(off_d) - DW'(off_b);
        diff_abs = diff[DW-1] ? DW'(-diff) : DW'(diff);
        mag_diff = diff_abs[W-1:0];
        mag_a    = coef_a[W-1] ? W'(-coef_a) : W'(coef_a);
        mag_c    = coef_c[W-1] ? W'(-coef_c) : W'(coef_c);
    end
endmodule

// File: rtl/gdt_euclid_step.sv
// One subtractive Euclid step, plus detection that the pair has settled.
module gdt_euclid_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] x_next,
    output logic [W-1:0] y_next,
    output logic         settled,
    output logic [W-1:0] gcd_val
);
    always_comb begin
        settled = (x == '0) || (y == '0) || (x == y);
        gcd_val = x | y;
        if (x > y) begin
            x_next = x - y;
            y_next = y;
        end else begin
            x_next = x;
            y_next = y - x;
        end
    end
endmodule

// File: rtl/gcd_dep_tester.sv
module gcd_dep_tester
    import gdt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic signed [W-1:0] coef_a_i,
    input  logic signed [W-1:0] off_b_i,
    input  logic signed [W-1:0] coef_c_i,
    input  logic signed [W-1:0] off_d_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                dep_o,
    output logic                indep_o
);
    gdt_state_e state_q, state_d;
    logic [W-1:0] x_q, x_d, y_q, y_d, r_q, r_d;
    logic [W-1:0] mag_a, mag_c, mag_diff;
    logic [W-1:0] x_nx, y_nx, gcd_val;
    logic         settled;
    logic         fin, fin_dep, launch;

    gdt_prep #(.W(W)) u_prep (
        .coef_a   (coef_a_i),
        .off_b    (off_b_i),
        .coef_c   (coef_c_i),
        .off_d    (off_d_i),
        .mag_a    (mag_a),
        .mag_c    (mag_c),
        .mag_diff (mag_diff)
    );

    gdt_euclid_step #(.W(W)) u_step (
        .x       (x_q),
        .y       (y_q),
        .x_next  (x_nx),
        .y_next  (y_nx),
        .settled (settled),
        .gcd_val (gcd_val)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        x_d     = x_q;
        y_d     = y_q;
        r_d     = r_q;
        fin     = 1'b0;
        fin_dep = 1'b0;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    launch  = 1'b1;
                    state_d = ST_REDUCE;
                    x_d     = mag_a;
                    y_d     = mag_c;
                    r_d     = mag_diff;
                end
            end
            ST_REDUCE: begin
                if (settled) begin
                    state_d = ST_DIVIDE;
                    x_d     = gcd_val;
                end else begin
                    x_d = x_nx;
                    y_d = y_nx;
                end
            end
            ST_DIVIDE: begin
                if ((x_q != '0) && (r_q >= x_q)) begin
                    r_d = r_q - x_q;
                end else begin
                    state_d = ST_IDLE;
                    fin     = 1'b1;
                    fin_dep = (r_q == '0);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            x_q     <= '0;
            y_q     <= '0;
            r_q     <= '0;
        end else begin
            state_q <= state_d;
            x_q     <= x_d;
            y_q     <= y_d;
            r_q     <= r_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            dep_o   <= 1'b0;
            indep_o <= 1'b0;
        end else begin
            done_o <= fin;
            if (fin) begin
                dep_o   <= fin_dep;
                indep_o <= !fin_dep;
            end else if (launch) begin
                dep_o   <= 1'b0;
                indep_o <= 1'b0;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    done_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && (dep_o ^ indep_o)));
    // R11
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(dep_o) && $stable(indep_o)));
    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE) |=> (state_q != ST_REDUCE));
    // R2
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !dep_o && !indep_o));
    // R8
    reduce_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_REDUCE) && !settled) |=> ((x_q + y_q) < $past(x_q + y_q)));
endmodule

// File: tb/gcd_dep_tester_tb.sv
`timescale 1ns/1ps
module gcd_dep_tester_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic signed [15:0] ca, ob, cc, od;
    logic busy, done, dep, indep;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural model state
    int  m_cnt = 0;
    bit  m_busy = 0, m_done = 0, m_dep = 0, m_indep = 0, m_pend = 0;

    always #4 clk = ~clk;

    gcd_dep_tester #(.W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .coef_a_i(ca), .off_b_i(ob), .coef_c_i(cc), .off_d_i(od),
        .busy_o(busy), .done_o(done), .dep_o(dep), .indep_o(indep)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Latency (edges after the start edge) and verdict, from the requirements
    function automatic void predict(int a, int b, int c, int d, output int lat, output bit dp);
        int x = iabs(a);
        int y = iabs(c);
        int r = iabs(d - b);
        int sg = 0;
        int g;
        int sm;
        while (x != 0 && y != 0 && x != y) begin
            if (x > y) x -= y; else y -= x;
            sg++;
        end
        g  = (x == 0) ? y : x;
        sm = (g == 0) ? 0 : r / g;
        dp = (g == 0) ? (r == 0) : ((r % g) == 0);
        lat = sg + sm + 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dep = 0; m_indep = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_dep = m_pend; m_indep = !m_pend;
                end
            end else if (start) begin
                int l;
                bit p;
                predict(int'(ca), int'(ob), int'(cc), int'(od), l, p);
                m_cnt = l; m_pend = p; m_busy = 1; m_dep = 0; m_indep = 0;
            end
        end
    end

    task automatic cmp(string nm, logic act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", cur_req, nm, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        cmp("busy_o", busy, m_busy);
        cmp("done_o", done, m_done);
        cmp("dep_o", dep, m_dep);
        cmp("indep_o", indep, m_indep);
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic go(int a, int b, int c, int d);
        @(negedge clk);
        ca = 16'(a); ob = 16'(b); cc = 16'(c); od = 16'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(int extra);
        while (busy === 1'b1) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; ca = '0; ob = '0; cc = '0; od = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R4"; go(2, 0, 4, 1); finish_run(2);
        cur_req = "R3"; go(6, 3, 9, 0); finish_run(2);
        cur_req = "R3"; go(12, 100, 18, 4); finish_run(1);
        cur_req = "R5"; go(0, 5, 0, 5); finish_run(2);
        cur_req = "R5"; go(0, 5, 0, 4); finish_run(2);
        cur_req = "R6"; go(0, 2, 7, 16); finish_run(2);
        cur_req = "R6"; go(5, 0, 0, 3); finish_run(2);
        cur_req = "R7"; go(-4, 10, 6, 0); finish_run(2);
        cur_req = "R7"; go(-3, -7, -9, 1); finish_run(2);
        cur_req = "R7"; go(-32768, 32767, -32768, -32768); finish_run(2);
        cur_req = "R8"; go(35, 1, 1, 40); finish_run(0);
        // R2 back-to-back: start right after the done pulse
        cur_req = "R2"; go(4, 0, 6, 2); finish_run(0);
        // R10: starts while busy must not disturb the test
        cur_req = "R10"; go(21, 0, 13, 50);
        ca = 16'sd2; ob = 16'sd0; cc = 16'sd2; od = 16'sd0;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        finish_run(0);
        // R11: verdict held while idle, R9 pulse length
        cur_req = "R11"; repeat (10) @(negedge clk);
        cur_req = "R9"; go(9, 1, 3, 2); finish_run(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule